// File: doc/BRIEF.md
# Dual-Clock Sample FIFO with Event-Driven Pointer Alignment

This block is an eight-entry sample FIFO. It sits between the clock domain that delivers input samples and the clock domain that feeds a converter. One sample is written on every write-clock edge and one is read on every read-clock edge, so the two address pointers never stop moving. The distance between them comes only from the moment each pointer was last re-initialised. The write pointer is re-initialised by a write-side sync event. The read pointer is re-initialised by a read-side alignment event. Each pointer is then placed so that the read side trails the write side by four entries.

Each event source is chosen by configuration inputs. The sync event can come from an external strobe. It can also come from a software-driven control bit, where only a 0-to-1 change counts. A sync-only setting routes the same sync source to the read side as well, and the read side then ignores its own strobe.

Each event crosses into its domain through a two-flop synchroniser and a rising-edge detector. The domain resets clear the status flags but leave the pointers alone. The output stays at zero until the read side has seen an alignment event. A sticky collision flag reports when the read pointer meets the synchronised write pointer.

Top module: `align_fifo`

## Requirements
- R1: A write-side sync event places the sample presented at that write edge in slot 4 (parameter WR_INIT). The write pointer then advances by one per write-clock edge, wrapping modulo 8.
- R2: A read-side event reads slot WR_INIT-4 (slot 0) at that edge and advances one slot per read-clock edge. When both domains run on one clock and both events fall on the same edge, rd_data after read edge e+4 equals the wr_data sampled at edge e.
- R3: With sync_only high, the write-side sync source also drives the read-side event, and align_in has no effect.
- R4: With sw_sync_en high, the sync source is sw_sync_bit and only its 0-to-1 change produces an event. sync_in then has no effect.
- R5: Deasserting either domain reset does not re-initialise the pointers. rd_rst_n low clears aligned and collision and forces rd_data to 0. A fresh event is needed before data flows again.
- R6: aligned sets at the read edge where the first read-side event takes effect and stays set until rd_rst_n. While aligned is 0, rd_data is 0.
- R7: An event source rising before clock edge k takes effect at edge k+2. Each rising edge of the source gives exactly one single-cycle pointer re-initialisation, however long the source stays high.
- R8: collision sets when, with both sides aligned, the read pointer equals the write pointer as synchronised into the read domain. It stays set until rd_rst_n or the next read-side event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_data | input | DW | Sample written on every write-clock edge |
| sync_in | input | 1 | External write-side sync strobe (asynchronous) |
| align_in | input | 1 | External read-side alignment strobe (asynchronous) |
| sw_sync_en | input | 1 | Selects sw_sync_bit instead of sync_in as the sync source |
| sw_sync_bit | input | 1 | Software sync bit; its rising edge is the sync event |
| sync_only | input | 1 | Routes the sync source to the read side and ignores align_in |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_data | output | DW | Sample read on every read-clock edge; zero until aligned |
| aligned | output | 1 | Read side has seen at least one alignment event |
| collision | output | 1 | Sticky: read pointer met synchronised write pointer |

## Verification
The bench runs both domains from one clock. A strobe raised before edge k re-initialises its pointer at edge k+2. The bench therefore samples aligned one cycle before and exactly at that edge to pin down the synchroniser latency. Samples follow a fixed function of the cycle count. After read edge e+4, rd_data must equal the value presented at edge e, and stream checks start only four cycles after the last event. The collision flag depends on a two-edge write-pointer crossing, so the bench raises the alignment strobe six cycles after the sync strobe to force a meeting. It raises it a multiple of eight cycles later to avoid one, and reads the flag several cycles after the event.

// File: rtl/align_fifo.sv
module align_fifo #(
  parameter int DW      = 16,
  parameter int AW      = 3,
  parameter int WR_INIT = 4,
  parameter int GAP     = 4,
  parameter int STG     = 2
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          sync_in,
  input  logic          align_in,
  input  logic          sw_sync_en,
  input  logic          sw_sync_bit,
  input  logic          sync_only,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  output logic [DW-1:0] rd_data,
  output logic          aligned,
  output logic          collision
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] WR_START = AW'(WR_INIT);
  localparam logic [AW-1:0] RD_START = AW'(WR_INIT - GAP);
  localparam logic [AW-1:0] ONE      = AW'(1);

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic           wsrc, wprev, wr_evt, wr_aligned;
  logic [STG-1:0] wsy;
  logic [AW-1:0]  wr_ptr, wr_addr, wr_nxt, wr_gray;

  assign wsrc    = sw_sync_en ? sw_sync_bit : sync_in;
  assign wr_evt  = wsy[STG-1] & ~wprev;
  assign wr_addr = wr_evt ? WR_START : wr_ptr;
  assign wr_nxt  = wr_addr + ONE;

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wsy        <= '0;
      wprev      <= 1'b0;
      wr_aligned <= 1'b0;
    end else begin
      wsy   <= {wsy[STG-2:0], wsrc};
      wprev <= wsy[STG-1];
      if (wr_evt) wr_aligned <= 1'b1;
    end

  always_ff @(posedge wr_clk) begin
    mem[wr_addr] <= wr_data;
    wr_ptr       <= wr_nxt;
    wr_gray      <= wr_nxt ^ (wr_nxt >> 1);
  end

  // read domain
  logic           rsrc, rprev, rd_evt, rd_aligned;
  logic [STG-1:0] rsy, wa_s;
  logic [AW-1:0]  rd_ptr, rd_addr, wr_ptr_s;
  logic [AW-1:0]  wg_s [STG];

  assign rsrc    = sync_only ? wsrc : align_in;
  assign rd_evt  = rsy[STG-1] & ~rprev;
  assign rd_addr = rd_evt ? RD_START : rd_ptr;
  assign aligned = rd_aligned;

  always_comb begin
    wr_ptr_s[AW-1] = wg_s[STG-1][AW-1];
    for (int i = AW - 2; i >= 0; i--)
      wr_ptr_s[i] = wr_ptr_s[i+1] ^ wg_s[STG-1][i];
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rsy        <= '0;
      rprev      <= 1'b0;
      wa_s       <= '0;
      rd_aligned <= 1'b0;
      rd_data    <= '0;
      collision  <= 1'b0;
      for (int i = 0; i < STG; i++) wg_s[i] <= '0;
    end else begin
      rsy   <= {rsy[STG-2:0], rsrc};
      rprev <= rsy[STG-1];
      wa_s  <= {wa_s[STG-2:0], wr_aligned};
      wg_s[0] <= wr_gray;
      for (int i = 1; i < STG; i++) wg_s[i] <= wg_s[i-1];
      if (rd_evt) rd_aligned <= 1'b1;
      rd_data <= (rd_evt | rd_aligned) ? mem[rd_addr] : '0;
      if (rd_evt)
        collision <= 1'b0;
      else if (rd_aligned && wa_s[STG-1] && rd_ptr == wr_ptr_s)
        collision <= 1'b1;
    end

  always_ff @(posedge rd_clk)
    rd_ptr <= rd_addr + ONE;

endmodule

// File: rtl/align_fifo_chk.sv
module align_fifo_chk #(
  parameter int DW      = 16,
  parameter int AW      = 3,
  parameter int WR_INIT = 4,
  parameter int GAP     = 4
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          wr_evt,
  input logic          rd_evt,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [DW-1:0] rd_data,
  input logic          aligned,
  input logic          collision
);
  localparam logic [AW-1:0] WR_NEXT = AW'(WR_INIT + 1);
  localparam logic [AW-1:0] RD_NEXT = AW'(WR_INIT - GAP + 1);

  a_r1_wr_ptr_init: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_evt |=> wr_ptr == WR_NEXT);
  a_r2_rd_ptr_init: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_evt |=> rd_ptr == RD_NEXT);
  a_r7_single_pulse: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_evt |=> !wr_evt);
  a_r7_single_pulse_rd: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_evt |=> !rd_evt);
  a_r6_zero_until_aligned: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !aligned |-> rd_data == '0);
  a_r6_aligned_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    aligned |=> aligned);
  a_r8_coll_needs_align: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    collision |-> aligned);
  a_r8_coll_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    collision && !rd_evt |=> collision);
endmodule

bind align_fifo align_fifo_chk #(.DW(DW), .AW(AW), .WR_INIT(WR_INIT), .GAP(GAP)) u_chk (.*);

// File: tb/align_fifo_test.sv
`timescale 1ns/1ps
module align_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wr_data = '0;
  logic        sync_in = 0, align_in = 0, sw_sync_en = 0, sw_sync_bit = 0, sync_only = 0;
  logic [15:0] rd_data;
  logic        aligned, collision;
  int cyc = 0, n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  align_fifo uut (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_data(wr_data),
    .sync_in(sync_in), .align_in(align_in), .sw_sync_en(sw_sync_en),
    .sw_sync_bit(sw_sync_bit), .sync_only(sync_only),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_data(rd_data),
    .aligned(aligned), .collision(collision));

  function automatic logic [15:0] pat(int x);
    return 16'(x * 37 + 451);
  endfunction

  initial forever begin
    @(negedge clk);
    wr_data = pat(cyc);
  end

  task automatic check(bit ok, string req, int got, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic stream(int n, string req);
    repeat (3) @(negedge clk);
    repeat (n) begin
      @(negedge clk);
      check(rd_data == pat(cyc - 5), req, rd_data, pat(cyc - 5));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; sync_in = 0; align_in = 0; sw_sync_en = 0; sw_sync_bit = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(aligned == 0, "R6 aligned after reset", aligned, 0);
    check(collision == 0, "R8 collision after reset", collision, 0);
    check(rd_data == 0, "R5 rd_data after reset", rd_data, 0);
  endtask

  task automatic t_sync_only();
    do_reset();
    sync_only = 1;
    @(negedge clk); sync_in = 1;
    @(negedge clk); check(aligned == 0, "R7 not yet at k", aligned, 0);
    @(negedge clk); check(aligned == 0, "R7 not yet at k+1", aligned, 0);
    @(negedge clk); check(aligned == 1, "R3 R6 aligned at k+2", aligned, 1);
    repeat (5) @(negedge clk);
    check(aligned == 1, "R7 long strobe single event", aligned, 1);
    sync_in = 0;
    stream(10, "R1 R2 R7 latency 4");
    @(negedge clk); align_in = 1;
    repeat (4) @(negedge clk); align_in = 0;
    stream(8, "R3 align ignored in sync_only");
  endtask

  task automatic t_align_ignored();
    do_reset();
    sync_only = 1;
    @(negedge clk); align_in = 1;
    repeat (4) @(negedge clk); align_in = 0;
    repeat (6) @(negedge clk);
    check(aligned == 0, "R3 align_in ignored", aligned, 0);
    check(rd_data == 0, "R6 zero while unaligned", rd_data, 0);
  endtask

  task automatic t_sw_sync();
    do_reset();
    sync_only = 1; sw_sync_en = 1; sw_sync_bit = 0;
    @(negedge clk); sync_in = 1;
    repeat (4) @(negedge clk); sync_in = 0;
    repeat (6) @(negedge clk);
    check(aligned == 0, "R4 sync_in ignored", aligned, 0);
    sw_sync_bit = 1;
    @(negedge clk);
    @(negedge clk); check(aligned == 0, "R4 R7 sw edge latency", aligned, 0);
    @(negedge clk); check(aligned == 1, "R4 sw rising edge aligns", aligned, 1);
    stream(8, "R4 data after sw sync");
    sw_sync_bit = 0;
    stream(4, "R4 falling edge no event");
  endtask

  task automatic t_reset_keeps();
    do_reset();
    repeat (8) @(negedge clk);
    check(aligned == 0, "R5 reset needs new event", aligned, 0);
    check(rd_data == 0, "R5 rd_data zero after reset", rd_data, 0);
  endtask

  task automatic t_separate();
    do_reset();
    sync_only = 0;
    @(negedge clk); sync_in = 1; align_in = 1;
    repeat (3) @(negedge clk);
    check(aligned == 1, "R2 align_in event", aligned, 1);
    sync_in = 0; align_in = 0;
    stream(10, "R2 separate events latency 4");
    check(collision == 0, "R8 no collision at gap 4", collision, 0);
  endtask

  task automatic t_collision();
    int s;
    do_reset();
    sync_only = 0;
    @(negedge clk); sync_in = 1; s = cyc;
    repeat (4) @(negedge clk); sync_in = 0;
    repeat (2) @(negedge clk); align_in = 1;
    repeat (2) @(negedge clk);
    check(collision == 0 && aligned == 0, "R8 clear before read event", collision, 0);
    repeat (2) @(negedge clk); align_in = 0;
    repeat (6) @(negedge clk);
    check(collision == 1, "R8 collision detected", collision, 1);
    repeat (3) @(negedge clk);
    check(collision == 1, "R8 collision sticky", collision, 1);
    while (((cyc - s) % 8) != 0) @(negedge clk);
    align_in = 1;
    repeat (3) @(negedge clk);
    check(collision == 0, "R8 cleared by read event", collision, 0);
    align_in = 0;
    stream(8, "R2 realigned after collision");
    check(collision == 0, "R8 stays clear", collision, 0);
  endtask

  initial begin
    t_reset_state();
    t_sync_only();
    t_align_ignored();
    t_sw_sync();
    t_reset_keeps();
    t_separate();
    t_collision();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule